// File: doc/BRIEF.md
# Configuration Change Protection Unit

This block sits on a microcontroller's I/O bus and guards a few sensitive control registers against stray writes. Software opens them by writing a fixed key value (0xD8) to a lock register. For the next four retired instructions, writes to the guarded registers take effect. While that window is open the block raises an interrupt-inhibit output, so that no interrupt can split the unlock sequence. When the window closes, the inhibit drops. Any interrupt that became pending in the meantime is then taken by the interrupt controller's usual priority; this block holds no interrupt state and so cannot lose one.

Four simple stand-in registers sit behind the gate so the gating can be observed: a clock-source select, a clock prescaler, a watchdog control and a core control register. The first two are guarded in full. The last two are guarded only on a bit mask, and their other bits stay writable at all times. Writes to the stand-ins and reads of them go through the same bus slave port as the lock register.

Top module: `cfg_guard_top`

## Requirements
- R1: After reset, the lock register reads 0x00, `irqInhibit` is 0 and all four stand-in registers hold 0x00.
- R2: Writing 0xD8 to address 0x3C opens the window from the next cycle on. Writing any other value to 0x3C neither opens a closed window nor closes an open one.
- R3: The window closes after exactly four `instRetire` pulses, counted from the cycle after the key write. With three or fewer pulses, guarded writes are still accepted.
- R4: `irqInhibit` is 1 exactly while the window is open. It falls in the cycle after the clock edge that samples the fourth retire pulse.
- R5: A read of address 0x3C returns bit 0 = 1 while the window is open and 0 otherwise. Bits 7:1 always read 0.
- R6: The clock-source select register (0x36) and the clock prescaler register (0x37) change only when written while the window is open. A write to them with the window closed leaves them unchanged.
- R7: In the watchdog control register (0x31), bits 4:0 are guarded: bit 4 is the enable and bits 3:0 are the prescaler select. With the window closed, a write keeps bits 4:0 and updates bits 7:5.
- R8: In the core control register (0x3A), only bit 4 is guarded: bit 4 is the brown-out-off-in-sleep control. With the window closed, a write keeps bit 4 and updates all other bits.
- R9: A key write while the window is open restarts the count, so four further retire pulses are needed before the window closes.
- R10: Reset is asynchronous and active low. It closes the window, clears `irqInhibit` and clears the stand-in registers without waiting for a clock edge.
- R11: A read of a stand-in register address returns that register's value. A read of any address that maps to no register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 6 | I/O address |
| ioWdata | input | 8 | Write data |
| ioWe | input | 1 | Write strobe, one cycle per write |
| ioRdata | output | 8 | Read data for ioAddr (combinational) |
| instRetire | input | 1 | One pulse per retired instruction |
| irqInhibit | output | 1 | High while the unlock window is open |
| clkSelQ | output | 8 | Clock-source select stand-in |
| clkDivQ | output | 8 | Clock prescaler stand-in |
| wdogCtlQ | output | 8 | Watchdog control stand-in |
| coreCtlQ | output | 8 | Core control stand-in |

## Verification
The lock register is hit with all 256 data values. This separates an exact-match key compare from a partial one, since only 0xD8 may open the window. Both masked registers are swept over all 256 data values twice, once with the window open and once with it closed. The expected value is computed as (old AND mask) OR (new AND NOT mask). This catches a wrong or shifted mask, and a gate applied to the wrong bits. The number of retire pulses after a key write is swept from zero to five. This pins the window length to four and tells an off-by-one counter apart from a correct one. Further runs cover a key rewrite, a non-key write while the window is open, and a reset in the middle of a window.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NUM_GUARDED = 4;

  // index 0: clock select, 1: prescaler, 2: watchdog control, 3: core control
  localparam logic [NUM_GUARDED-1:0][ADDR_W-1:0] GUARD_ADDR =
    {6'h3A, 6'h31, 6'h37, 6'h36};
  // set bit = write requires an open window
  localparam logic [NUM_GUARDED-1:0][DATA_W-1:0] GUARD_MASK =
    {8'h10, 8'h1F, 8'hFF, 8'hFF};

  typedef struct packed {
    logic                   winOpen;
    logic [NUM_GUARDED-1:0] regSel;
  } guardStrobe_t;
endpackage

// File: rtl/cfg_guard_ctl.sv
module cfg_guard_ctl
  import cfg_guard_pkg::*;
#(
  parameter int              WINDOW_CYCLES = 4,
  parameter logic [7:0]      UNLOCK_KEY    = 8'hD8,
  parameter logic [5:0]      LOCK_ADDR     = 6'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic              ioWe,
  input  logic              instRetire,
  output guardStrobe_t      strobe
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] winCnt;
  logic             keyHit;

  assign keyHit = ioWe && (ioAddr == LOCK_ADDR) && (ioWdata == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      winCnt <= '0;
    else if (keyHit)
      winCnt <= CNT_LOAD;
    else if (instRetire && (winCnt != '0))
      winCnt <= winCnt - 1'b1;
  end

  assign strobe.winOpen = (winCnt != '0);

  for (genvar i = 0; i < NUM_GUARDED; i++) begin : g_sel
    assign strobe.regSel[i] = ioWe && (ioAddr == GUARD_ADDR[i]);
  end
endmodule

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
#(
  parameter logic [5:0] LOCK_ADDR = 6'h3C
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  guardStrobe_t                       strobe,
  input  logic [ADDR_W-1:0]                  ioAddr,
  input  logic [DATA_W-1:0]                  ioWdata,
  output logic [NUM_GUARDED-1:0][DATA_W-1:0] regQ,
  output logic [DATA_W-1:0]                  ioRdata
);
  for (genvar i = 0; i < NUM_GUARDED; i++) begin : g_reg
    logic [DATA_W-1:0] nextVal;
    assign nextVal = strobe.winOpen ? ioWdata
                   : ((ioWdata & ~GUARD_MASK[i]) | (regQ[i] & GUARD_MASK[i]));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[i] <= '0;
      else if (strobe.regSel[i])
        regQ[i] <= nextVal;
    end
  end

  always_comb begin
    ioRdata = '0;
    if (ioAddr == LOCK_ADDR)
      ioRdata = {{(DATA_W-1){1'b0}}, strobe.winOpen};
    for (int i = 0; i < NUM_GUARDED; i++)
      if (ioAddr == GUARD_ADDR[i])
        ioRdata = regQ[i];
  end
endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import cfg_guard_pkg::*;
#(
  parameter int         WINDOW_CYCLES = 4,
  parameter logic [7:0] UNLOCK_KEY    = 8'hD8,
  parameter logic [5:0] LOCK_ADDR     = 6'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] ioAddr,
  input  logic [7:0] ioWdata,
  input  logic       ioWe,
  output logic [7:0] ioRdata,
  input  logic       instRetire,
  output logic       irqInhibit,
  output logic [7:0] clkSelQ,
  output logic [7:0] clkDivQ,
  output logic [7:0] wdogCtlQ,
  output logic [7:0] coreCtlQ
);
  guardStrobe_t                       strobe;
  logic [NUM_GUARDED-1:0][DATA_W-1:0] regQ;

  cfg_guard_ctl #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .UNLOCK_KEY   (UNLOCK_KEY),
    .LOCK_ADDR    (LOCK_ADDR)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .ioAddr    (ioAddr),
    .ioWdata   (ioWdata),
    .ioWe      (ioWe),
    .instRetire(instRetire),
    .strobe    (strobe)
  );

  cfg_guard_dp #(
    .LOCK_ADDR(LOCK_ADDR)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .ioAddr (ioAddr),
    .ioWdata(ioWdata),
    .regQ   (regQ),
    .ioRdata(ioRdata)
  );

  assign irqInhibit = strobe.winOpen;
  assign clkSelQ    = regQ[0];
  assign clkDivQ    = regQ[1];
  assign wdogCtlQ   = regQ[2];
  assign coreCtlQ   = regQ[3];
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int         WINDOW_CYCLES = 4,
  parameter logic [7:0] UNLOCK_KEY    = 8'hD8,
  parameter logic [5:0] LOCK_ADDR     = 6'h3C
) (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] ioAddr,
  input logic [7:0] ioWdata,
  input logic       ioWe,
  input logic [7:0] ioRdata,
  input logic       instRetire,
  input logic       irqInhibit,
  input logic [7:0] clkSelQ,
  input logic [7:0] clkDivQ,
  input logic [7:0] wdogCtlQ,
  input logic [7:0] coreCtlQ
);
  logic keyHit;
  logic armed;
  int   retireSeen;

  assign keyHit = ioWe && (ioAddr == LOCK_ADDR) && (ioWdata == UNLOCK_KEY);

  // retire pulses observed since the most recent key write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      retireSeen <= 0;
    end else if (keyHit) begin
      armed      <= 1'b1;
      retireSeen <= 0;
    end else if (armed && instRetire && retireSeen < WINDOW_CYCLES) begin
      retireSeen <= retireSeen + 1;
    end
  end

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rstN)
    keyHit |=> irqInhibit);

  a_r2_stays_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!irqInhibit && !keyHit) |=> !irqInhibit);

  a_r3_open_until_count: assert property (@(posedge clk) disable iff (!rstN)
    (armed && retireSeen < WINDOW_CYCLES) |-> irqInhibit);

  a_r3_closed_after_count: assert property (@(posedge clk) disable iff (!rstN)
    (armed && retireSeen == WINDOW_CYCLES) |-> !irqInhibit);

  a_r5_lock_readback: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr == LOCK_ADDR) |-> (ioRdata == {7'b0, irqInhibit}));

  a_r6_clksel_locked: assert property (@(posedge clk) disable iff (!rstN)
    !irqInhibit |=> $stable(clkSelQ));

  a_r6_clkdiv_locked: assert property (@(posedge clk) disable iff (!rstN)
    !irqInhibit |=> $stable(clkDivQ));

  a_r7_wdog_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqInhibit |=> ((wdogCtlQ & 8'h1F) == ($past(wdogCtlQ) & 8'h1F)));

  a_r8_core_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqInhibit |=> ((coreCtlQ & 8'h10) == ($past(coreCtlQ) & 8'h10)));
endmodule

bind cfg_guard_top cfg_guard_chk #(
  .WINDOW_CYCLES(WINDOW_CYCLES),
  .UNLOCK_KEY   (UNLOCK_KEY),
  .LOCK_ADDR    (LOCK_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ioAddr    (ioAddr),
  .ioWdata   (ioWdata),
  .ioWe      (ioWe),
  .ioRdata   (ioRdata),
  .instRetire(instRetire),
  .irqInhibit(irqInhibit),
  .clkSelQ   (clkSelQ),
  .clkDivQ   (clkDivQ),
  .wdogCtlQ  (wdogCtlQ),
  .coreCtlQ  (coreCtlQ)
);

// File: tb/tb_cfg_guard_top.sv
module tb_cfg_guard_top;
  localparam logic [5:0] A_LOCK = 6'h3C;
  localparam logic [5:0] A_SEL  = 6'h36;
  localparam logic [5:0] A_DIV  = 6'h37;
  localparam logic [5:0] A_WDOG = 6'h31;
  localparam logic [5:0] A_CORE = 6'h3A;
  localparam logic [7:0] KEY    = 8'hD8;
  localparam logic [7:0] M_WDOG = 8'h1F;
  localparam logic [7:0] M_CORE = 8'h10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] ioAddr = '0;
  logic [7:0] ioWdata = '0;
  logic       ioWe = 1'b0;
  logic [7:0] ioRdata;
  logic       instRetire = 1'b0;
  logic       irqInhibit;
  logic [7:0] clkSelQ, clkDivQ, wdogCtlQ, coreCtlQ;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cfg_guard_top dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWdata(ioWdata), .ioWe(ioWe),
    .ioRdata(ioRdata), .instRetire(instRetire), .irqInhibit(irqInhibit),
    .clkSelQ(clkSelQ), .clkDivQ(clkDivQ), .wdogCtlQ(wdogCtlQ), .coreCtlQ(coreCtlQ)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWe = 1'b1;
    @(negedge clk);
    ioWe = 1'b0;
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); instRetire = 1'b1;
      @(negedge clk); instRetire = 1'b0;
    end
  endtask

  task automatic ioRead(input logic [5:0] a, output logic [7:0] d);
    ioAddr = a;
    #1;
    d = ioRdata;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] prevDiv;
    logic [7:0] expW, expC;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    ioRead(A_LOCK, rd);
    check(rd == 8'h00, "R1 lock read", rd, 0);
    check(irqInhibit == 1'b0, "R1 inhibit", irqInhibit, 0);
    check({clkSelQ, clkDivQ, wdogCtlQ, coreCtlQ} == 32'h0, "R1 regs",
          {clkSelQ, clkDivQ, wdogCtlQ, coreCtlQ}, 0);

    // R2 every non-key value leaves the window closed; R6 write rejected
    for (int k = 0; k < 256; k++) begin
      if (k[7:0] == KEY) continue;
      ioWrite(A_LOCK, k[7:0]);
      ioWrite(A_SEL, k[7:0] ^ 8'h5A);
      check(irqInhibit == 1'b0 && clkSelQ == 8'h00, "R2 non-key value",
            {irqInhibit, clkSelQ}, 0);
    end

    // R2/R4/R5 key opens; R6 write accepted
    ioWrite(A_LOCK, KEY);
    check(irqInhibit == 1'b1, "R4 inhibit after key", irqInhibit, 1);
    ioRead(A_LOCK, rd);
    check(rd == 8'h01, "R5 lock read open", rd, 1);
    ioWrite(A_SEL, 8'hA5);
    check(clkSelQ == 8'hA5, "R6 clock select unlocked", clkSelQ, 8'hA5);
    ioRead(A_SEL, rd);
    check(rd == 8'hA5, "R11 read clock select", rd, 8'hA5);
    ioRead(6'h00, rd);
    check(rd == 8'h00, "R11 unmapped read", rd, 0);

    // R7/R8 open window: full writes
    for (int d = 0; d < 256; d++) begin
      ioWrite(A_WDOG, d[7:0]);
      ioWrite(A_CORE, d[7:0]);
      check(wdogCtlQ == d[7:0], "R7 watchdog unlocked", wdogCtlQ, d);
      check(coreCtlQ == d[7:0], "R8 core unlocked", coreCtlQ, d);
    end

    // R3/R4 close
    retire(4);
    check(irqInhibit == 1'b0, "R4 inhibit after four retires", irqInhibit, 0);
    ioRead(A_LOCK, rd);
    check(rd == 8'h00, "R5 lock read closed", rd, 0);

    // R7/R8 closed window: masked writes
    for (int d = 0; d < 256; d++) begin
      expW = (wdogCtlQ & M_WDOG) | (d[7:0] & ~M_WDOG);
      expC = (coreCtlQ & M_CORE) | (d[7:0] & ~M_CORE);
      ioWrite(A_WDOG, d[7:0]);
      ioWrite(A_CORE, d[7:0]);
      check(wdogCtlQ == expW, "R7 watchdog locked", wdogCtlQ, expW);
      check(coreCtlQ == expC, "R8 core locked", coreCtlQ, expC);
    end

    // R3 window length sweep, R6 prescaler
    prevDiv = clkDivQ;
    for (int n = 0; n < 6; n++) begin
      ioWrite(A_LOCK, KEY);
      retire(n);
      check(irqInhibit == (n < 4), "R3 window after retires", irqInhibit, (n < 4));
      ioWrite(A_DIV, 8'h10 + 8'(n));
      if (n < 4) prevDiv = 8'h10 + 8'(n);
      check(clkDivQ == prevDiv, "R6 prescaler gate", clkDivQ, prevDiv);
      retire(4);
    end

    // R9 restart
    ioWrite(A_LOCK, KEY);
    retire(3);
    ioWrite(A_LOCK, KEY);
    retire(3);
    check(irqInhibit == 1'b1, "R9 restart keeps open", irqInhibit, 1);
    ioWrite(A_SEL, 8'h3C);
    check(clkSelQ == 8'h3C, "R9 write after restart", clkSelQ, 8'h3C);
    retire(1);
    check(irqInhibit == 1'b0, "R9 closes after four", irqInhibit, 0);

    // R2 non-key write while open does not close
    ioWrite(A_LOCK, KEY);
    ioWrite(A_LOCK, 8'h00);
    check(irqInhibit == 1'b1, "R2 non-key keeps open", irqInhibit, 1);
    ioRead(A_LOCK, rd);
    check(rd == 8'h01, "R5 lock read after non-key", rd, 1);

    // R10 async reset mid-window
    @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    check(irqInhibit == 1'b0, "R10 inhibit cleared", irqInhibit, 0);
    check(clkSelQ == 8'h00 && wdogCtlQ == 8'h00, "R10 regs cleared",
          {clkSelQ, wdogCtlQ}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    ioRead(A_LOCK, rd);
    check(rd == 8'h00, "R10 lock read after reset", rd, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule